// File: doc/BRIEF.md
# Per-Pixel Colour Gain Steering

This block picks, for every pixel, one of four stored gain codes and presents it to a downstream programmable-gain stage. Which code is picked depends on where the pixel sits in the colour filter pattern of the sensor. A two-bit steering mode selects the pattern. In the progressive pattern, suited to a red/green/blue Bayer mosaic, even lines alternate codes 0 and 1 and odd lines alternate codes 2 and 3. In the interlaced pattern the field, rather than the line, picks the pair of codes. In the mosaic-separate pattern the code cycles through all four entries on every pixel.

A pixel-rate enable advances the block. The pattern phase is pulled back to its start by the line-reset strobe that the pixel counter raises on the first pixel of each line. A line-parity flag flips on every line reset and is cleared by a vertical sync pulse. The four gain codes and the mode are loaded through a small write port. The steering index is registered on one enabled pixel and the gain code it selects is registered on the next, so the output trails its pixel by two enabled clocks.

Top module: `pix_gain_steer`

## Requirements
- R1: After reset `gain_out` is 0, all four gain codes are 0, the mode is progressive (00), the pattern phase is 0 and the first line is treated as even.
- R2: A write with `cfg_we` high and `cfg_addr` 0 to 3 loads `cfg_data` into gain code 0 to 3. Address 4 loads the mode from `cfg_data[1:0]`. Addresses 5 to 7 change nothing.
- R3: An index formed on an enabled pixel selects the gain code that appears on `gain_out` after the following enabled pixel. The code is taken from the gain registers as they stand at that second pixel.
- R4: The pixel that carries `line_rst` uses pattern phase 0. Each later enabled pixel of the line advances the phase by one, modulo 4.
- R5: Mode 00 (progressive): index = {line parity, phase bit 0}. Even lines give 0,1,0,1,... and odd lines give 2,3,2,3,...
- R6: The parity of a line is the stored next-line parity, which toggles on every line reset. An enabled `vsync` clears the stored parity to even. If `vsync` coincides with `line_rst`, that line is even and the one after it is odd.
- R7: Mode 01 (interlaced): index = {`field_odd`, phase bit 0}, with `field_odd` sampled on the pixel.
- R8: Mode 10 (mosaic separate): index = phase, cycling 0,1,2,3 from each line reset.
- R9: Mode 11 behaves exactly like mode 00.
- R10: While `pix_en` is low, `gain_out`, the phase and the parity state do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-rate enable; all steering state advances only when high |
| line_rst | input | 1 | Pixel-counter reset strobe, on the first pixel of a line |
| vsync | input | 1 | Vertical sync pulse, clears the stored line parity |
| field_odd | input | 1 | Field identifier used by the interlaced pattern |
| cfg_we | input | 1 | Write strobe for gain and mode registers |
| cfg_addr | input | 3 | Write address: 0-3 gain codes, 4 mode |
| cfg_data | input | 8 | Write data |
| gain_out | output | 8 | Gain code selected for the pixel |

## Verification
The hardest situation to reach from the ports is a vertical sync that lands on the same pixel as a line reset, or in the middle of a line. These cases decide the parity of the lines that follow, and that parity only shows up in the gain codes two enabled pixels later. The stimulus sweeps every mode and both fields. It starts each frame with a coincident sync and line reset, and it injects a lone mid-line sync before the last line. The pixel enable is dropped every third pixel, so the two-stage pipeline is seen both holding and advancing. Writes to the unused addresses are followed by full lines, so that any stray change would appear on the output.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

  typedef enum logic [1:0] {
    MODE_PROG     = 2'b00,
    MODE_INTL     = 2'b01,
    MODE_MOSAIC   = 2'b10,
    MODE_PROG_ALT = 2'b11
  } steer_mode_e;

  localparam int unsigned NUM_GAINS = 4;
  localparam int unsigned IDX_W     = $clog2(NUM_GAINS);
  localparam int unsigned ADDR_W    = 3;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd4;

endpackage

// File: rtl/pgs_gain_bank.sv
module pgs_gain_bank
  import pgs_pkg::*;
#(
  parameter int unsigned GAIN_W = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_we,
  input  logic [ADDR_W-1:0]                  cfg_addr,
  input  logic [GAIN_W-1:0]                  cfg_data,
  output logic [NUM_GAINS-1:0][GAIN_W-1:0]   gains,
  output steer_mode_e                        mode
);

  steer_mode_e mode_d;
  logic        mode_we;

  genvar g;
  generate
    for (g = 0; g < NUM_GAINS; g++) begin : g_reg
      localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(g);
      logic              hit;
      logic [GAIN_W-1:0] val_d;

      always_comb begin
        hit   = cfg_we && (cfg_addr == SLOT);
        val_d = hit ? cfg_data : gains[g];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gains[g] <= '0;
        else if (hit) gains[g] <= val_d;
      end
    end
  endgenerate

  always_comb begin
    mode_we = cfg_we && (cfg_addr == ADDR_MODE);
    mode_d  = mode_we ? steer_mode_e'(cfg_data[1:0]) : mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= MODE_PROG;
    else if (mode_we) mode <= mode_d;
  end

  assert_unused_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr > ADDR_MODE) |=> ($stable(gains) && $stable(mode)));

  assert_no_write_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(gains) && $stable(mode)));

endmodule

// File: rtl/pgs_phase_track.sv
module pgs_phase_track
  import pgs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic             line_rst,
  input  logic             vsync,
  output logic [IDX_W-1:0] ph_eff,
  output logic             par_eff
);

  logic [IDX_W-1:0] ph_q, ph_d;
  logic             np_q, np_d;
  logic             cp_q, cp_d;
  logic             np_eff;

  always_comb begin
    ph_eff  = line_rst ? '0 : ph_q;
    np_eff  = vsync ? 1'b0 : np_q;
    par_eff = line_rst ? np_eff : cp_q;
    ph_d    = ph_q;
    np_d    = np_q;
    cp_d    = cp_q;
    if (pix_en) begin
      ph_d = ph_eff + IDX_W'(1);
      if (line_rst) begin
        cp_d = np_eff;
        np_d = ~np_eff;
      end else begin
        np_d = np_eff;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
      np_q <= 1'b0;
      cp_q <= 1'b0;
    end else if (pix_en) begin
      ph_q <= ph_d;
      np_q <= np_d;
      cp_q <= cp_d;
    end
  end

  assert_parity_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && line_rst && !vsync) |=> (np_q != $past(np_q)) && (cp_q == $past(np_q)));

  assert_vsync_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && vsync && !line_rst) |=> !np_q);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(ph_q) && $stable(np_q) && $stable(cp_q)));

endmodule

// File: rtl/pgs_index_map.sv
module pgs_index_map
  import pgs_pkg::*;
(
  input  steer_mode_e      mode,
  input  logic [IDX_W-1:0] ph_eff,
  input  logic             par_eff,
  input  logic             field_odd,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    unique case (mode)
      MODE_INTL:   idx = {field_odd, ph_eff[0]};
      MODE_MOSAIC: idx = ph_eff;
      default:     idx = {par_eff, ph_eff[0]};
    endcase
  end

endmodule

// File: rtl/pix_gain_steer.sv
module pix_gain_steer
  import pgs_pkg::*;
#(
  parameter int unsigned GAIN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic              line_rst,
  input  logic              vsync,
  input  logic              field_odd,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [GAIN_W-1:0] cfg_data,
  output logic [GAIN_W-1:0] gain_out
);

  logic [NUM_GAINS-1:0][GAIN_W-1:0] gains;
  steer_mode_e                      mode;
  logic [IDX_W-1:0]                 ph_eff;
  logic                             par_eff;
  logic [IDX_W-1:0]                 idx_d;
  logic [IDX_W-1:0]                 idx_q;
  logic [GAIN_W-1:0]                gain_d;

  pgs_gain_bank #(.GAIN_W(GAIN_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_data (cfg_data),
    .gains    (gains),
    .mode     (mode)
  );

  pgs_phase_track u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_en   (pix_en),
    .line_rst (line_rst),
    .vsync    (vsync),
    .ph_eff   (ph_eff),
    .par_eff  (par_eff)
  );

  pgs_index_map u_map (
    .mode      (mode),
    .ph_eff    (ph_eff),
    .par_eff   (par_eff),
    .field_odd (field_odd),
    .idx       (idx_d)
  );

  always_comb gain_d = gains[idx_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      gain_out <= '0;
    end else if (pix_en) begin
      idx_q    <= idx_d;
      gain_out <= gain_d;
    end
  end

  assert_mosaic_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && line_rst && mode == MODE_MOSAIC) |=> (idx_q == '0));

  assert_intl_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && mode == MODE_INTL) |=> (idx_q[1] == $past(field_odd)));

  assert_line_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && line_rst && mode != MODE_MOSAIC) |=> (idx_q[0] == 1'b0));

  assert_output_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(gain_out));

endmodule

// File: tb/pix_gain_steer_tb.sv
module pix_gain_steer_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pix_en, line_rst, vsync, field_odd, cfg_we;
  logic [2:0] cfg_addr;
  logic [7:0] cfg_data;
  logic [7:0] gain_out;

  always #10 clk = ~clk;

  pix_gain_steer u_dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .line_rst(line_rst),
    .vsync(vsync), .field_odd(field_odd), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .gain_out(gain_out)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] m_gain [4];
  logic [1:0] m_mode, m_ph, m_idx;
  logic       m_np, m_cp;
  logic [7:0] m_out;

  task automatic chk(input string tag);
    n_chk++;
    if (gain_out !== m_out) begin
      n_fail++;
      $display("FAIL %s: gain_out=%0h expected %0h", tag, gain_out, m_out);
    end
  endtask

  // Called at a negative edge; returns at the next negative edge.
  task automatic step(input logic pe, input logic lr, input logic vs,
                      input logic fo, input string tag);
    logic [1:0] ph_e, idx;
    logic       np_e, par;
    pix_en = pe; line_rst = lr; vsync = vs; field_odd = fo; cfg_we = 1'b0;
    @(posedge clk);
    if (pe) begin
      ph_e = lr ? 2'd0 : m_ph;
      np_e = vs ? 1'b0 : m_np;
      par  = lr ? np_e : m_cp;
      case (m_mode)
        2'b01:   idx = {fo, ph_e[0]};
        2'b10:   idx = ph_e;
        default: idx = {par, ph_e[0]};
      endcase
      m_out = m_gain[m_idx];
      m_idx = idx;
      m_ph  = ph_e + 2'd1;
      if (lr) begin m_cp = np_e; m_np = ~np_e; end
      else m_np = np_e;
    end
    @(negedge clk);
    chk(tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    pix_en = 1'b0; line_rst = 1'b0; vsync = 1'b0;
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(posedge clk);
    if (a < 3'd4) m_gain[a] = d;
    else if (a == 3'd4) m_mode = d[1:0];
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R2");
  endtask

  task automatic run_line(input int len, input logic vs0, input logic fo,
                          input string tag);
    for (int i = 0; i < len; i++) begin
      step(1'b1, i == 0, vs0 && i == 0, fo, (i == 0) ? "R4" : tag);
      if (i % 3 == 2) step(1'b0, 1'b0, 1'b0, fo, "R10");
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R3: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    string tag;
    rst_n = 1'b0; pix_en = 1'b0; line_rst = 1'b0; vsync = 1'b0;
    field_odd = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
    for (int k = 0; k < 4; k++) m_gain[k] = 8'h00;
    m_mode = 2'b00; m_ph = 2'd0; m_idx = 2'd0; m_np = 1'b0; m_cp = 1'b0; m_out = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1");
    run_line(4, 1'b0, 1'b0, "R1");

    wr(3'd0, 8'h1A); wr(3'd1, 8'h2B); wr(3'd2, 8'h3C); wr(3'd3, 8'h4D);
    wr(3'd5, 8'hE5); wr(3'd6, 8'hE6); wr(3'd7, 8'hE7);
    run_line(5, 1'b1, 1'b0, "R2");
    run_line(5, 1'b0, 1'b0, "R2");

    for (int m = 0; m < 4; m++) begin
      wr(3'd4, 8'hF0 | 8'(m));
      case (m)
        0: tag = "R5";
        1: tag = "R7";
        2: tag = "R8";
        default: tag = "R9";
      endcase
      for (int f = 0; f < 2; f++) begin
        run_line(5, 1'b1, f[0], tag);
        run_line(6, 1'b0, f[0], tag);
        run_line(7, 1'b0, f[0], tag);
        step(1'b1, 1'b0, 1'b1, f[0], "R6");
        run_line(4, 1'b0, f[0], tag);
        run_line(6, 1'b0, f[0], "R6");
      end
      step(1'b1, 1'b0, 1'b0, 1'b0, "R3");
      step(1'b1, 1'b0, 1'b0, 1'b0, "R3");
    end

    wr(3'd4, 8'h00);
    run_line(3, 1'b1, 1'b0, "R5");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R3");
    wr(3'd1, 8'h77);
    step(1'b1, 1'b0, 1'b0, 1'b0, "R3");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R3");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R3");
    run_line(6, 1'b0, 1'b1, "R5");

    summary();
    $finish;
  end

endmodule